// File: doc/BRIEF.md
# Shift-Capable Bit-Sliced ALU

This block is a purely combinational arithmetic and logic unit of parameterised width. A 4-bit operation code picks one of eleven functions of the two operands. The functions are three carry-chain functions (sum, difference, increment), a complement, three bitwise combinations, and single-position shifts in both directions. The result appears on the output in the same cycle as the inputs. Nothing in the block is clocked.

Inside the block, a small decoder turns the operation code into a struct of select and conditioning strobes. A datapath then builds the result from identical one-bit slices that share a single ripple carry chain. The end positions are handled outside the slice array: the carry into bit 0, the fill that enters the most significant bit on a right shift, and the fill that enters bit 0 on a left shift. Every slice therefore carries the same logic.

Top module: `shiftAlu`

## Requirements
- R1: Operation code 0000 (ADD) gives input1 + input2 modulo 2^W.
- R2: Operation code 0001 (SUB) gives input1 - input2 modulo 2^W.
- R3: Operation code 0010 (INCR) gives input1 + 1 modulo 2^W, so an all-ones operand wraps to zero.
- R4: Operation code 0011 (INV) gives the bitwise complement of input1.
- R5: Operation codes 0100 (XOR), 0101 (OR) and 0110 (AND) give the matching bitwise combination of input1 and input2.
- R6: Operation code 1000 (SRA) moves input1 right by one position and repeats input1[W-1] in out[W-1].
- R7: Operation code 1001 (SRL) moves input1 right by one position and places 0 in out[W-1].
- R8: Operation codes 1010 (SLA) and 1011 (SLL) both move input1 left by one position and place 0 in out[0]. The old MSB is lost.
- R9: Operation codes 0111, 1100, 1101, 1110 and 1111 give an all-zero output.
- R10: For INCR, INV, SRA, SRL, SLA and SLL, the value on input2 has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| input1 | input | W | First operand; the only operand of the single-operand functions |
| input2 | input | W | Second operand |
| aluop | input | 4 | Operation code |
| out | output | W | Result |

## Verification
In a single evaluation, the slice at bit 0 must take in the injected carry (set for SUB and INCR) and the left-shift fill. The slice at the top must resolve the last carry and the right-shift fill. Both end paths are therefore exercised together.

A narrow instance with W=4 is swept over every operation code and every pair of operands. This drives carry wrap-around, borrow through all bits, and shifts with the MSB set under each code. A full-width instance then takes directed corner operands. Each result is compared with a value the bench computes arithmetically from the requirement.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_SUB  = 4'b0001,
    OP_INCR = 4'b0010,
    OP_INV  = 4'b0011,
    OP_XOR  = 4'b0100,
    OP_OR   = 4'b0101,
    OP_AND  = 4'b0110,
    OP_SRA  = 4'b1000,
    OP_SRL  = 4'b1001,
    OP_SLA  = 4'b1010,
    OP_SLL  = 4'b1011
  } aluOp_e;

  localparam int unsigned OP_BITS = 4;

  // strobes from control to datapath; select fields are one-hot or all zero
  typedef struct packed {
    logic sumEn;
    logic invEn;
    logic xorEn;
    logic orEn;
    logic andEn;
    logic shrEn;
    logic shlEn;
    logic bInvert;
    logic bZero;
    logic carryIn;
    logic arithFill;
  } aluCtrl_t;

endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [OP_BITS-1:0] aluop,
  output aluCtrl_t           ctrl
);

  always_comb begin
    ctrl = '0;
    case (aluop)
      OP_ADD:  ctrl.sumEn = 1'b1;
      OP_SUB: begin
        ctrl.sumEn   = 1'b1;
        ctrl.bInvert = 1'b1;
        ctrl.carryIn = 1'b1;
      end
      OP_INCR: begin
        ctrl.sumEn   = 1'b1;
        ctrl.bZero   = 1'b1;
        ctrl.carryIn = 1'b1;
      end
      OP_INV:  ctrl.invEn = 1'b1;
      OP_XOR:  ctrl.xorEn = 1'b1;
      OP_OR:   ctrl.orEn  = 1'b1;
      OP_AND:  ctrl.andEn = 1'b1;
      OP_SRA: begin
        ctrl.shrEn     = 1'b1;
        ctrl.arithFill = 1'b1;
      end
      OP_SRL:  ctrl.shrEn = 1'b1;
      OP_SLA,
      OP_SLL:  ctrl.shlEn = 1'b1;
      default: ctrl = '0;
    endcase
  end

  // R9: at most one result select active; none for unused codes
  always_comb begin
    assert_sel_onehot_R9: assert ($onehot0({ctrl.sumEn, ctrl.invEn, ctrl.xorEn,
                                            ctrl.orEn, ctrl.andEn, ctrl.shrEn,
                                            ctrl.shlEn}))
      else $error("result select not one-hot");
  end

endmodule

// File: rtl/aluSlice.sv
module aluSlice
  import aluPkg::*;
(
  input  aluCtrl_t ctrl,
  input  logic     a,
  input  logic     b,
  input  logic     cin,
  input  logic     fromUpper,
  input  logic     fromLower,
  output logic     res,
  output logic     cout
);

  logic bEff;
  logic sumBit;

  always_comb begin
    bEff   = ~ctrl.bZero & (b ^ ctrl.bInvert);
    sumBit = a ^ bEff ^ cin;
    cout   = (a & bEff) | (cin & (a ^ bEff));
    res    = (ctrl.sumEn & sumBit)
           | (ctrl.invEn & ~a)
           | (ctrl.xorEn & (a ^ b))
           | (ctrl.orEn  & (a | b))
           | (ctrl.andEn & (a & b))
           | (ctrl.shrEn & fromUpper)
           | (ctrl.shlEn & fromLower);
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int unsigned W = 16
) (
  input  aluCtrl_t       ctrl,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  output logic [W-1:0]   result
);

  localparam int unsigned MSB = W - 1;

  logic [W:0]   carry;
  logic [W+1:0] nbr;   // nbr[k+1] is opA[k]; the two ends carry the fills
  logic         msbFill;
  logic         lsbFill;

  // end-bit logic, kept out of the slice array
  always_comb begin
    msbFill  = ctrl.arithFill & opA[MSB];
    lsbFill  = 1'b0;
    carry[0] = ctrl.carryIn;
    nbr      = {msbFill, opA, lsbFill};
  end

  for (genvar i = 0; i < W; i++) begin : g_slice
    aluSlice u_slice (
      .ctrl      (ctrl),
      .a         (opA[i]),
      .b         (opB[i]),
      .cin       (carry[i]),
      .fromUpper (nbr[i+2]),
      .fromLower (nbr[i]),
      .res       (result[i]),
      .cout      (carry[i+1])
    );
  end

  // carry-out of the top slice is dropped on purpose (no flags)
  logic unusedCarry;
  assign unusedCarry = carry[W];

endmodule

// File: rtl/shiftAlu.sv
module shiftAlu
  import aluPkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]       input1,
  input  logic [W-1:0]       input2,
  input  logic [OP_BITS-1:0] aluop,
  output logic [W-1:0]       out
);

  aluCtrl_t ctrl;

  aluControl u_ctrl (
    .aluop (aluop),
    .ctrl  (ctrl)
  );

  aluDatapath #(.W(W)) u_dp (
    .ctrl   (ctrl),
    .opA    (input1),
    .opB    (input2),
    .result (out)
  );

  always_comb begin
    if (aluop == OP_SRA)
      assert_sra_msb_R6: assert (out[W-1] == input1[W-1])
        else $error("SRA msb not kept");
    if (aluop == OP_SRL)
      assert_srl_msb_R7: assert (out[W-1] == 1'b0)
        else $error("SRL msb not zero");
    if (aluop == OP_SLA || aluop == OP_SLL)
      assert_shl_lsb_R8: assert (out[0] == 1'b0)
        else $error("left shift lsb not zero");
    if (aluop == OP_INV)
      assert_inv_R4: assert (out == ~input1)
        else $error("INV result wrong");
    if (aluop == 4'b0111 || aluop[3:2] == 2'b11)
      assert_unused_zero_R9: assert (out == '0)
        else $error("unused code gave nonzero");
  end

endmodule

// File: tb/shiftAlu_tb.sv
module shiftAlu_tb_top;

  localparam int unsigned WB = 16;
  localparam int unsigned WS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [WB-1:0] in1, in2, res;
  logic [3:0]    op;
  logic [WS-1:0] sIn1, sIn2, sRes;
  logic [3:0]    sOp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  shiftAlu #(.W(WB)) dut_i (.input1(in1), .input2(in2), .aluop(op), .out(res));
  shiftAlu #(.W(WS)) dutSmall_i (.input1(sIn1), .input2(sIn2), .aluop(sOp), .out(sRes));

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input int w);
    logic [31:0] m;
    logic [31:0] r;
    m = (32'd1 << w) - 32'd1;
    a = a & m;
    b = b & m;
    case (o)
      4'b0000: r = a + b;
      4'b0001: r = a - b;
      4'b0010: r = a + 32'd1;
      4'b0011: r = ~a;
      4'b0100: r = a ^ b;
      4'b0101: r = a | b;
      4'b0110: r = a & b;
      4'b1000: r = (a >> 1) | (a & (32'd1 << (w - 1)));
      4'b1001: r = a >> 1;
      4'b1010, 4'b1011: r = a << 1;
      default: r = 32'd0;
    endcase
    return r & m;
  endfunction

  function automatic string tagOf(input logic [3:0] o);
    case (o)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0011: return "R4";
      4'b0100, 4'b0101, 4'b0110: return "R5";
      4'b1000: return "R6";
      4'b1001: return "R7";
      4'b1010, 4'b1011: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic big(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b);
    @(posedge clk);
    op = o; in1 = a; in2 = b;
    @(negedge clk);
    check(tagOf(o), {16'd0, res}, model(o, {16'd0, a}, {16'd0, b}, WB));
  endtask

  initial begin
    op = 4'b0000; in1 = '0; in2 = '0;
    sOp = 4'b0000; sIn1 = '0; sIn2 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset-state", {16'd0, res}, 32'd0);

    // exhaustive sweep of the narrow instance; single-operand codes see every
    // input2 value against a model that ignores it (R10)
    for (int o = 0; o < 16; o++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          @(posedge clk);
          sOp = 4'(o); sIn1 = 4'(a); sIn2 = 4'(b);
          @(negedge clk);
          check(tagOf(4'(o)), {28'd0, sRes}, model(4'(o), 32'(a), 32'(b), WS));
        end

    // full-width corners
    big(4'b0000, 16'hFFFF, 16'h0001);  // R1 wrap
    big(4'b0000, 16'h7FFF, 16'h7FFF);
    big(4'b0001, 16'h0000, 16'h0001);  // R2 borrow through all bits
    big(4'b0001, 16'h8000, 16'h0001);
    big(4'b0010, 16'hFFFF, 16'h1234);  // R3 wrap to zero
    big(4'b0011, 16'hA5A5, 16'hFFFF);  // R4
    big(4'b0100, 16'hF0F0, 16'hFF00);  // R5
    big(4'b0101, 16'hF0F0, 16'h0F0F);
    big(4'b0110, 16'hF0F0, 16'hFF00);
    big(4'b1000, 16'h8001, 16'hFFFF);  // R6 msb repeated
    big(4'b1001, 16'h8001, 16'hFFFF);  // R7 zero fill
    big(4'b1010, 16'hC003, 16'hFFFF);  // R8 msb lost
    big(4'b1011, 16'hC003, 16'h0000);
    big(4'b1111, 16'hFFFF, 16'hFFFF);  // R9
    big(4'b0111, 16'hFFFF, 16'hFFFF);

    // R10: single-operand codes with two different input2 values match
    for (int k = 0; k < 6; k++) begin
      logic [3:0] o;
      logic [15:0] first;
      o = (k == 0) ? 4'b0010 : (k == 1) ? 4'b0011 : (k == 2) ? 4'b1000 :
          (k == 3) ? 4'b1001 : (k == 4) ? 4'b1010 : 4'b1011;
      @(posedge clk); op = o; in1 = 16'h9C35; in2 = 16'h0000;
      @(negedge clk); first = res;
      @(posedge clk); in2 = 16'hFFFF;
      @(negedge clk);
      check("R10", {16'd0, res}, {16'd0, first});
    end

    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

endmodule